// File: doc/BRIEF.md
# Reference Clock Qualification Monitor

This block decides whether one reference clock is clean enough to be picked by a downstream input selector. It works entirely on a fast, free-running monitor clock. The reference is brought into that domain through a synchronizer. Rising edges are detected there, and the number of monitor cycles between consecutive rising edges is measured.

Each measured interval is checked against two windows. If the interval is longer than the late threshold, a pulse went missing and the block raises a missing-pulse fault. If it is shorter than the early threshold, a runt or extra pulse arrived and the block raises a runt fault. Each check has its own enable. A qualification timer raises the valid flag only after the enabled checks have stayed quiet for a programmed number of monitor cycles. For a gapped reference, set the late threshold wide enough to cover the number of pulses that may be absent. Both thresholds should include margin for worst-case cycle-to-cycle jitter.

There is no data stream here, so there is no valid/ready handshake. Every configuration input and every status output is a plain level sampled or driven on each monitor clock. Threshold and timer values are counts of monitor cycles.

Top module: `refclk_qual_mon`

## Requirements
- R1: The interval is the count of monitor cycles between successive synchronized rising edges. When more than `late_cyc` cycles pass without an edge, `miss_fault` goes high. It stays high until the next edge, and the edge that arrives clears it. An interval exactly equal to `late_cyc` raises no fault.
- R2: A gapped reference whose longest gap (missing pulses included) is no more than `late_cyc` cycles never raises `miss_fault` and does not disturb `ref_valid`.
- R3: An edge whose interval is less than `early_cyc` sets `runt_fault`. The flag stays set until an edge arrives whose interval is at least `early_cyc`. An interval exactly equal to `early_cyc` is clean. The first edge after reset is never judged a runt.
- R4: `late_en` = 0 holds `miss_fault` at 0, and `early_en` = 0 holds `runt_fault` at 0. A disabled check never lowers `ref_valid`.
- R5: `ref_valid` rises only after at least one reference edge has been seen, and then only after exactly `valid_cyc` consecutive monitor cycles in which no enabled fault flag was high.
- R6: An enabled fault flag drops `ref_valid` on the next monitor cycle and restarts the qualification count from zero.
- R7: The interval counter saturates at the late threshold. A stopped reference keeps `miss_fault` high for as long as it stays stopped. The first edge after a restart clears it and does not raise `runt_fault`.
- R8: The reference passes through a two-stage synchronizer plus one edge-detect stage. Each rising edge of the reference yields exactly one edge event in the monitor domain.
- R9: A change to `late_cyc`, `early_cyc` or `valid_cyc` is captured at the next reference edge. An interval is judged against the values captured at the edge that began it. Before the first edge, the live values are used.
- R10: During and right after reset, `miss_fault`, `runt_fault` and `ref_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock under watch (asynchronous) |
| late_en | input | 1 | Enables the missing-pulse check |
| early_en | input | 1 | Enables the runt-pulse check |
| late_cyc | input | 16 | Longest allowed interval, in monitor cycles |
| early_cyc | input | 16 | Shortest allowed interval, in monitor cycles |
| valid_cyc | input | 20 | Clean cycles required before valid |
| miss_fault | output | 1 | Missing-pulse fault (gated by its enable) |
| runt_fault | output | 1 | Runt-pulse fault (gated by its enable) |
| ref_valid | output | 1 | Reference qualified for selection |

## Verification
The bench sets both thresholds equal to the reference period. An off-by-one in either comparison would then raise a fault on a perfectly clean clock, and a period one cycle longer or shorter must still be caught. It counts the clean cycles between the end of a runt fault and the rise of valid, which exposes a timer that qualifies one cycle early or late. It stops the reference for hundreds of cycles to catch a counter that wraps and silently drops the missing-pulse fault. It also drops pulses from a gapped clock to catch a late window that is too tight. Finally, it changes the early threshold between two edges: a design that applies the new value at once, rather than at the next edge, would flag the wrong interval.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  localparam int unsigned CNT_W_DEF   = 16;
  localparam int unsigned VAL_W_DEF   = 20;
  localparam int unsigned SYNC_DEPTH  = 2;

  // raw per-check fault state leaving the interval checker
  typedef struct packed {
    logic miss;
    logic runt;
  } fault_t;
endpackage

// File: rtl/refmon_edge_sync.sv
module refmon_edge_sync #(
  parameter int unsigned STAGES = refmon_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic edge_p
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] shr;

  generate
    for (genvar g = 0; g < LEN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) shr[g] <= 1'b0;
          else        shr[g] <= ref_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) shr[g] <= 1'b0;
          else        shr[g] <= shr[g-1];
        end
      end
    end
  endgenerate

  assign edge_p = shr[STAGES-1] & ~shr[STAGES];

  // R8
  one_edge_per_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_p |=> !edge_p);
endmodule

// File: rtl/refmon_cfg_latch.sv
module refmon_cfg_latch #(
  parameter int unsigned CNT_W = refmon_pkg::CNT_W_DEF,
  parameter int unsigned VAL_W = refmon_pkg::VAL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_p,
  input  logic [CNT_W-1:0] late_in,
  input  logic [CNT_W-1:0] early_in,
  input  logic [VAL_W-1:0] valid_in,
  output logic [CNT_W-1:0] late_q,
  output logic [CNT_W-1:0] early_q,
  output logic [VAL_W-1:0] valid_q
);
  logic armed;
  logic take;

  // follow live values until the first edge, then only on edges
  assign take = edge_p | ~armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      late_q  <= '0;
      early_q <= '0;
      valid_q <= '0;
    end else begin
      if (edge_p) armed <= 1'b1;
      if (take) begin
        late_q  <= late_in;
        early_q <= early_in;
        valid_q <= valid_in;
      end
    end
  end

  // R9
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !edge_p) |=> ($stable(late_q) && $stable(early_q) && $stable(valid_q)));
endmodule

// File: rtl/refmon_interval.sv
module refmon_interval
  import refmon_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_p,
  input  logic [CNT_W-1:0] late_thr,
  input  logic [CNT_W-1:0] early_thr,
  output fault_t           raw,
  output logic             seen
);
  logic [CNT_W-1:0] cnt;   // cycles elapsed since last edge
  logic             at_late;
  logic             short_iv;

  assign at_late  = (cnt >= late_thr);
  assign short_iv = (cnt < early_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (edge_p) begin
      cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (!at_late) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      raw.miss <= 1'b0;
      raw.runt <= 1'b0;
    end else if (edge_p) begin
      seen     <= 1'b1;
      raw.miss <= 1'b0;
      raw.runt <= seen & short_iv;
    end else if (at_late) begin
      raw.miss <= 1'b1;
    end
  end

  // R1
  late_sets_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_p && cnt >= late_thr) |=> raw.miss);
  // R3
  short_sets_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && seen && cnt < early_thr) |=> raw.runt);
  // R7
  counter_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_p && cnt >= late_thr) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/refmon_qualify.sv
module refmon_qualify #(
  parameter int unsigned VAL_W = refmon_pkg::VAL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_any,
  input  logic             seen,
  input  logic [VAL_W-1:0] valid_thr,
  output logic             ref_valid
);
  logic [VAL_W-1:0] tmr;
  logic             reached;

  assign reached = ({1'b0, tmr} + 1'b1) >= {1'b0, valid_thr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr       <= '0;
      ref_valid <= 1'b0;
    end else if (fault_any || !seen) begin
      tmr       <= '0;
      ref_valid <= 1'b0;
    end else if (!ref_valid) begin
      if (reached) ref_valid <= 1'b1;
      else         tmr       <= tmr + 1'b1;
    end
  end

  // R6
  fault_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> !ref_valid);
  // R5
  rise_needs_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_valid) |-> ($past(!fault_any) && $past(seen)));
endmodule

// File: rtl/refclk_qual_mon.sv
module refclk_qual_mon
  import refmon_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned VAL_W = VAL_W_DEF
) (
  input  logic             clk_mon,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             late_en,
  input  logic             early_en,
  input  logic [CNT_W-1:0] late_cyc,
  input  logic [CNT_W-1:0] early_cyc,
  input  logic [VAL_W-1:0] valid_cyc,
  output logic             miss_fault,
  output logic             runt_fault,
  output logic             ref_valid
);
  logic             edge_p;
  logic [CNT_W-1:0] late_q;
  logic [CNT_W-1:0] early_q;
  logic [VAL_W-1:0] valid_q;
  fault_t           raw;
  logic             seen;

  refmon_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk_mon),
    .rst_n  (rst_n),
    .ref_in (ref_clk),
    .edge_p (edge_p)
  );

  refmon_cfg_latch #(.CNT_W(CNT_W), .VAL_W(VAL_W)) u_cfg (
    .clk      (clk_mon),
    .rst_n    (rst_n),
    .edge_p   (edge_p),
    .late_in  (late_cyc),
    .early_in (early_cyc),
    .valid_in (valid_cyc),
    .late_q   (late_q),
    .early_q  (early_q),
    .valid_q  (valid_q)
  );

  refmon_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk       (clk_mon),
    .rst_n     (rst_n),
    .edge_p    (edge_p),
    .late_thr  (late_q),
    .early_thr (early_q),
    .raw       (raw),
    .seen      (seen)
  );

  assign miss_fault = raw.miss & late_en;
  assign runt_fault = raw.runt & early_en;

  refmon_qualify #(.VAL_W(VAL_W)) u_qual (
    .clk       (clk_mon),
    .rst_n     (rst_n),
    .fault_any (miss_fault | runt_fault),
    .seen      (seen),
    .valid_thr (valid_q),
    .ref_valid (ref_valid)
  );

  // R10
  quiet_after_reset_chk: assert property (@(posedge clk_mon) disable iff (!rst_n)
    $rose(rst_n) |-> (!ref_valid && !miss_fault && !runt_fault));
endmodule

// File: tb/refclk_qual_mon_tb_top.sv
`timescale 1ns/1ps
module refclk_qual_mon_tb_top;
  localparam int RUNT_LEN = 6;
  localparam int VCYC     = 50;

  logic        clk_mon = 1'b0;
  logic        rst_n   = 1'b0;
  logic        ref_clk = 1'b0;
  logic        late_en = 1'b1, early_en = 1'b1;
  logic [15:0] late_cyc = 16'd30, early_cyc = 16'd10;
  logic [19:0] valid_cyc = 20'(VCYC);
  logic        miss_fault, runt_fault, ref_valid;

  int nchk = 0, nerr = 0;
  int gen_period = 20, cur_len = 20, ph = 0, skip_n = 0;
  bit gen_on = 0, runt_req = 0;

  always #10 clk_mon = ~clk_mon;

  refclk_qual_mon dut_i (
    .clk_mon(clk_mon), .rst_n(rst_n), .ref_clk(ref_clk),
    .late_en(late_en), .early_en(early_en),
    .late_cyc(late_cyc), .early_cyc(early_cyc), .valid_cyc(valid_cyc),
    .miss_fault(miss_fault), .runt_fault(runt_fault), .ref_valid(ref_valid)
  );

  // reference generator, period counted in monitor cycles
  always @(negedge clk_mon) begin
    if (!gen_on) begin
      ref_clk = 1'b0; ph = 0;
    end else begin
      if (ph == 0) begin
        if (runt_req) begin cur_len = RUNT_LEN; runt_req = 0; end
        else cur_len = gen_period;
        if (skip_n > 0) begin skip_n--; ref_clk = 1'b0; end
        else ref_clk = 1'b1;
      end else if (ph == cur_len / 2) ref_clk = 1'b0;
      ph = (ph + 1 >= cur_len) ? 0 : ph + 1;
    end
  end

  task automatic check(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_mon);
  endtask

  task automatic t_reset;
    cyc(5);
    check("R10", "miss in reset", miss_fault, 0);
    check("R10", "runt in reset", runt_fault, 0);
    check("R10", "valid in reset", ref_valid, 0);
    rst_n = 1'b1; gen_on = 1;
    cyc(1);
    check("R10", "valid after reset", ref_valid, 0);
  endtask

  task automatic t_clean;
    cyc(400);
    check("R5", "valid on clean clock", ref_valid, 1);
    check("R1", "no miss on clean clock", miss_fault, 0);
    check("R3", "no runt on clean clock", runt_fault, 0);
  endtask

  task automatic t_boundary;
    int hits = 0, vhi = 0;
    late_cyc = 16'd20; early_cyc = 16'd20;
    cyc(300);
    check("R1", "interval equal to late is clean", miss_fault, 0);
    check("R3", "interval equal to early is clean", runt_fault, 0);
    check("R5", "valid at exact boundary", ref_valid, 1);
    gen_period = 21;
    cyc(60);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_mon);
      if (miss_fault) hits++;
      if (ref_valid) vhi++;
    end
    check("R1", "period one above late flags miss", int'(hits > 0), 1);
    check("R6", "valid held low by repeated miss", vhi, 0);
    gen_period = 19;
    cyc(80);
    check("R3", "period one below early flags runt", runt_fault, 1);
    check("R6", "valid low under runt", ref_valid, 0);
    gen_period = 20; late_cyc = 16'd30; early_cyc = 16'd10;
    cyc(300);
    check("R5", "valid recovers", ref_valid, 1);
  endtask

  task automatic t_stop;
    @(posedge ref_clk);
    cyc(1); gen_on = 0;
    cyc(20);
    check("R1", "no miss before late", miss_fault, 0);
    cyc(25);
    check("R1", "miss after stop", miss_fault, 1);
    check("R6", "valid dropped on miss", ref_valid, 0);
    cyc(600);
    check("R7", "miss held while stopped", miss_fault, 1);
    gen_on = 1;
    cyc(10);
    check("R7", "restart clears miss", miss_fault, 0);
    check("R7", "restart raises no runt", runt_fault, 0);
    cyc(300);
    check("R5", "valid after restart", ref_valid, 1);
  endtask

  task automatic t_runt;
    int n = 0, cnt = 0;
    runt_req = 1;
    while (!runt_fault && n < 200) begin @(negedge clk_mon); n++; end
    check("R3", "runt detected", runt_fault, 1);
    cyc(2);
    check("R6", "valid drops after runt", ref_valid, 0);
    n = 0;
    while (runt_fault && n < 200) begin @(negedge clk_mon); n++; end
    check("R3", "good edge clears runt", runt_fault, 0);
    while (!ref_valid && cnt < 500) begin cnt++; @(negedge clk_mon); end
    check("R5", "clean cycles before valid", cnt, VCYC);
  endtask

  task automatic t_gap;
    int hits = 0, vlo = 0;
    late_cyc = 16'd70;
    cyc(100);
    skip_n = 2;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_mon);
      if (miss_fault) hits++;
      if (!ref_valid) vlo++;
    end
    check("R2", "two missing pulses tolerated", hits, 0);
    check("R2", "valid kept through gap", vlo, 0);
    skip_n = 3;
    hits = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_mon);
      if (miss_fault) hits++;
    end
    check("R1", "gap above late flags miss", int'(hits > 0), 1);
    late_cyc = 16'd30;
    cyc(300);
    check("R5", "valid after gap test", ref_valid, 1);
  endtask

  task automatic t_enable;
    int hits = 0, vlo = 0;
    early_en = 1'b0;
    runt_req = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_mon);
      if (runt_fault) hits++;
      if (!ref_valid) vlo++;
    end
    check("R4", "disabled runt flag silent", hits, 0);
    check("R4", "disabled runt keeps valid", vlo, 0);
    cyc(60);
    early_en = 1'b1;
    late_en = 1'b0; gen_on = 0;
    hits = 0; vlo = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_mon);
      if (miss_fault) hits++;
      if (!ref_valid) vlo++;
    end
    check("R4", "disabled miss flag silent", hits, 0);
    check("R4", "disabled miss keeps valid", vlo, 0);
    gen_on = 1;
    cyc(50);
    late_en = 1'b1;
    cyc(100);
    check("R4", "valid after re-enable", ref_valid, 1);
  endtask

  task automatic t_next_edge;
    @(posedge ref_clk);
    cyc(8);
    early_cyc = 16'd25;
    @(posedge ref_clk);
    cyc(8);
    check("R9", "old early used for current interval", runt_fault, 0);
    @(posedge ref_clk);
    cyc(8);
    check("R9", "new early used from next interval", runt_fault, 1);
    early_cyc = 16'd10;
    cyc(400);
    check("R9", "runt clears after restore", runt_fault, 0);
    check("R5", "valid after restore", ref_valid, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_mon);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    t_reset();
    t_clean();
    t_boundary();
    t_stop();
    t_runt();
    t_gap();
    t_enable();
    t_next_edge();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule